// File: doc/BRIEF.md
# System Exception State Register File

This block keeps the software-visible state of the fixed system exceptions: pending, active and enable bits, and an 8-bit priority for each exception number from 4 to 15. The implemented exceptions are the non-maskable interrupt (2), the memory-protection fault (4), the bus fault (5), the usage fault (6), the supervisor call (11), the debug monitor (12), the deferred service request (14) and the periodic timer exception (15). Software reaches this state through a word-addressed register port. Reads are combinational. Writes commit on the next rising clock edge.

An external prioritiser supplies the number of the active vector, a flag saying whether a preempted exception sits beneath it, the number of the pending vector, and an any-external-pending flag. The block folds these into the control/state read word. Hardware sources raise pendings through a set mask. The core's entry sequence marks an exception active with an acknowledge strobe, and its return sequence clears it with a done strobe. The block exports the priorities, the fault enables and the vector table base. It also drives a one-cycle system reset request, which is issued only after a keyed write.

Top module: `exc_sysreg_file`

## Requirements
- R1: A write to offset 0xD04 with bit 31, bit 28 or bit 26 set makes exception 2, 14 or 15 pending (`pend_o` bit 2, 14 or 15) after the next clock edge.
- R2: In a 0xD04 write, bit 27 clears pending for exception 14 and bit 25 clears pending for exception 15. Each clear is ignored when the matching set bit (28 or 26) of the same word is 1.
- R3: A read of 0xD04 returns the following fields. Bits [8:0] hold `active_vec_i` (0 means nothing is active). Bits [20:12] hold `pend_vec_i`. Bit 22 holds `ext_pend_i`. Bits 26, 28 and 31 hold the pending bits of exceptions 15, 14 and 2. Every other bit reads 0 apart from bit 11 (R4).
- R4: Bit 11 of the 0xD04 read is 1 when `active_vec_i` is 0 or `nested_i` is 0, and 0 otherwise.
- R5: Offsets 0xD18, 0xD1C and 0xD20 each hold four 8-bit priorities. They cover exception numbers 4–7, 8–11 and 12–15, with the lowest number in bits [7:0]. Written values read back unchanged and appear on `prio_o`, where byte k belongs to exception 4+k. Reset value is 0.
- R6: A read of 0xD24 returns active bits for exceptions 4, 5, 6, 11, 12, 14 and 15 in bits 0, 1, 3, 7, 8, 10 and 11. It returns pending bits for exceptions 6, 4, 5 and 11 in bits 12, 13, 14 and 15. It returns the fault enables for exceptions 4, 5 and 6 in bits 16, 17 and 18.
- R7: A write to 0xD24 changes only the three fault enables (bits 16–18, also on `fault_en_o[2:0]`). The pending and active state is unaffected.
- R8: A write to 0xD08 stores the word with bits [6:0] forced to 0. The stored value reads back at 0xD08 and drives `vto_o`.
- R9: A write to 0xD0C whose bits [31:16] equal 0x05FA and that has bit 0 or bit 2 set makes `sys_reset_o` high for exactly the one cycle after the write edge. No other 0xD0C write produces a pulse. Reads of 0xD0C return 0xFA050000.
- R10: A read of 0x004 returns NUM_EXT_IRQ/32 − 1, which is 1 for the default of 64.
- R11: Any access to an unmapped offset, or a write to 0x004, raises `err_o` in the same cycle and changes no state. Such a read returns 0.
- R12: `hw_set_i` bits set pending for implemented exceptions only, and win over a same-cycle software clear. An `ack_i` for exception n sets active n and clears pending n. A `done_i` for exception n clears active n. The pending and active vectors appear on `pend_o` and `act_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| err_o | output | 1 | Access to an unmapped or read-only offset |
| hw_set_i | input | 16 | Hardware pending-set mask, indexed by exception number |
| ack_i | input | 1 | Exception-entry strobe |
| ack_num_i | input | 4 | Exception number being entered |
| done_i | input | 1 | Exception-return strobe |
| done_num_i | input | 4 | Exception number being retired |
| active_vec_i | input | VEC_W | Active vector from the prioritiser, 0 when none |
| nested_i | input | 1 | A preempted exception lies beneath the active one |
| pend_vec_i | input | VEC_W | Highest pending vector from the prioritiser |
| ext_pend_i | input | 1 | Any external interrupt is pending |
| pend_o | output | 16 | Pending bits by exception number |
| act_o | output | 16 | Active bits by exception number |
| fault_en_o | output | 3 | Enables of exceptions 4, 5, 6 |
| prio_o | output | NUM_PRIO*PRIO_W | Priorities of exceptions 4..15 |
| vto_o | output | 32 | Vector table base |
| sys_reset_o | output | 1 | One-cycle system reset request |

## Verification
Every cycle, the assertions check the following. The set-over-clear rule for the deferred and timer pendings holds. The vector base follows the last write. The fault enables stay put except on a handler-control write. A reset pulse always follows a correctly keyed write. Entry makes the acknowledged exception active. Error accesses read zero. The return-to-base flag is high whenever nothing is active. Some behaviour only the bench scenarios can show: the exact bit packing of the control/state and handler-status words, the priority byte order, the reset-control key and bit selection, and the outcome when a hardware set races a software clear.

// File: rtl/exc_regs_pkg.sv
package exc_regs_pkg;

  localparam int unsigned EXC_NMI = 2;
  localparam int unsigned EXC_MEM = 4;
  localparam int unsigned EXC_BUS = 5;
  localparam int unsigned EXC_USE = 6;
  localparam int unsigned EXC_SVC = 11;
  localparam int unsigned EXC_DBG = 12;
  localparam int unsigned EXC_DEF = 14;
  localparam int unsigned EXC_TMR = 15;

  localparam logic [15:0] EXC_IMPL = 16'hD874;

  localparam logic [11:0] OFS_TYPE  = 12'h004;
  localparam logic [11:0] OFS_CTRL  = 12'hD04;
  localparam logic [11:0] OFS_VTO   = 12'hD08;
  localparam logic [11:0] OFS_RST   = 12'hD0C;
  localparam logic [11:0] OFS_PRI0  = 12'hD18;
  localparam logic [11:0] OFS_PRI1  = 12'hD1C;
  localparam logic [11:0] OFS_PRI2  = 12'hD20;
  localparam logic [11:0] OFS_HSTAT = 12'hD24;

  localparam logic [15:0] RST_KEY  = 16'h05FA;
  localparam logic [31:0] RST_READ = 32'hFA05_0000;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TYPE, SEL_CTRL, SEL_VTO, SEL_RST, SEL_PRI, SEL_HSTAT
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [11:0] a);
    case (a)
      OFS_TYPE:                     return SEL_TYPE;
      OFS_CTRL:                     return SEL_CTRL;
      OFS_VTO:                      return SEL_VTO;
      OFS_RST:                      return SEL_RST;
      OFS_PRI0, OFS_PRI1, OFS_PRI2: return SEL_PRI;
      OFS_HSTAT:                    return SEL_HSTAT;
      default:                      return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/exc_pend_state.sv
module exc_pend_state
  import exc_regs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ctrl_we_i,
  input  logic [31:0] wdata_i,
  input  logic [15:0] hw_set_i,
  input  logic        ack_i,
  input  logic [3:0]  ack_num_i,
  input  logic        done_i,
  input  logic [3:0]  done_num_i,
  output logic [15:0] pend_o,
  output logic [15:0] act_o
);

  logic [15:0] pend_q, act_q, pend_d, act_d;
  logic [15:0] sw_set, sw_clr, ack_vec, done_vec;
  logic        unused_wdata;

  assign unused_wdata = ^{wdata_i[30:29], wdata_i[24:0]};

  always_comb begin
    sw_set = '0;
    sw_clr = '0;
    if (ctrl_we_i) begin
      sw_set[EXC_NMI] = wdata_i[31];
      sw_set[EXC_DEF] = wdata_i[28];
      sw_set[EXC_TMR] = wdata_i[26];
      sw_clr[EXC_DEF] = wdata_i[27] & ~wdata_i[28];
      sw_clr[EXC_TMR] = wdata_i[25] & ~wdata_i[26];
    end
    ack_vec  = ack_i  ? (16'd1 << ack_num_i)  : 16'd0;
    done_vec = done_i ? (16'd1 << done_num_i) : 16'd0;
    pend_d   = ((pend_q & ~sw_clr & ~ack_vec) | sw_set | hw_set_i) & EXC_IMPL;
    act_d    = ((act_q & ~done_vec) | ack_vec) & EXC_IMPL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign pend_o = pend_q;
  assign act_o  = act_q;

  assert_set_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[28]) |=> pend_o[EXC_DEF]);

  assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && wdata_i[25] && !wdata_i[26] && !hw_set_i[EXC_TMR]) |=> !pend_o[EXC_TMR]);

  assert_ack_active_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && EXC_IMPL[ack_num_i]) |=> act_o[$past(ack_num_i)]);

endmodule

// File: rtl/exc_cfg_regs.sv
module exc_cfg_regs
  import exc_regs_pkg::*;
#(
  parameter int unsigned NUM_PRIO = 12,
  parameter int unsigned PRIO_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       pri_we_i,
  input  logic [1:0]                 pri_idx_i,
  input  logic                       hctl_we_i,
  input  logic                       vto_we_i,
  input  logic                       rst_we_i,
  input  logic [31:0]                wdata_i,
  output logic [NUM_PRIO*PRIO_W-1:0] prio_o,
  output logic [2:0]                 fault_en_o,
  output logic [31:0]                vto_o,
  output logic                       sys_reset_o
);

  localparam int unsigned LANES     = 4;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned VTO_ALIGN = 7;

  for (genvar g = 0; g < NUM_PRIO; g++) begin : g_prio
    localparam int unsigned WORD = g / LANES;
    localparam int unsigned LANE = g % LANES;
    logic [PRIO_W-1:0] pri_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pri_q <= '0;
      else if (pri_we_i && pri_idx_i == WORD[1:0])
        pri_q <= wdata_i[LANE*LANE_W +: PRIO_W];
    end
    assign prio_o[g*PRIO_W +: PRIO_W] = pri_q;
  end

  logic [2:0]  en_q;
  logic [31:0] vto_q;
  logic        rst_q;
  logic        key_ok;

  assign key_ok = (wdata_i[31:16] == RST_KEY) && (wdata_i[0] || wdata_i[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      vto_q <= '0;
      rst_q <= 1'b0;
    end else begin
      if (hctl_we_i) en_q <= wdata_i[18:16];
      if (vto_we_i)  vto_q <= {wdata_i[31:VTO_ALIGN], {VTO_ALIGN{1'b0}}};
      rst_q <= rst_we_i && key_ok;
    end
  end

  assign fault_en_o  = en_q;
  assign vto_o       = vto_q;
  assign sys_reset_o = rst_q;

  assert_vto_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vto_we_i |=> (vto_o[31:VTO_ALIGN] == $past(wdata_i[31:VTO_ALIGN])));

  assert_en_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hctl_we_i |=> $stable(fault_en_o));

  assert_key_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_reset_o) |-> ($past(rst_we_i) && $past(wdata_i[31:16]) == RST_KEY));

endmodule

// File: rtl/exc_status_mux.sv
module exc_status_mux
  import exc_regs_pkg::*;
#(
  parameter int unsigned NUM_EXT_IRQ = 64,
  parameter int unsigned NUM_PRIO    = 12,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned VEC_W       = 9
) (
  input  reg_sel_e                   sel_i,
  input  logic [1:0]                 pri_idx_i,
  input  logic [15:0]                pend_i,
  input  logic [15:0]                act_i,
  input  logic [2:0]                 fault_en_i,
  input  logic [NUM_PRIO*PRIO_W-1:0] prio_i,
  input  logic [31:0]                vto_i,
  input  logic [VEC_W-1:0]           active_vec_i,
  input  logic                       nested_i,
  input  logic [VEC_W-1:0]           pend_vec_i,
  input  logic                       ext_pend_i,
  output logic [31:0]                rdata_o
);

  localparam int unsigned LANES    = 4;
  localparam int unsigned LANE_W   = 8;
  localparam logic [31:0] TYPE_VAL = 32'((NUM_EXT_IRQ / 32) - 1);

  logic [31:0] ctrl_word, hstat_word, pri_word;
  logic        unused_bits;

  assign unused_bits = ^{pend_i[13:12], pend_i[10:7], pend_i[3], pend_i[1:0],
                         act_i[13], act_i[10:7], act_i[3:0]};

  always_comb begin
    ctrl_word = '0;
    ctrl_word[VEC_W-1:0]    = active_vec_i;
    ctrl_word[11]           = (active_vec_i == '0) || !nested_i;
    ctrl_word[12 +: VEC_W]  = pend_vec_i;
    ctrl_word[22]           = ext_pend_i;
    ctrl_word[26]           = pend_i[EXC_TMR];
    ctrl_word[28]           = pend_i[EXC_DEF];
    ctrl_word[31]           = pend_i[EXC_NMI];
  end

  always_comb begin
    hstat_word = '0;
    hstat_word[0]     = act_i[EXC_MEM];
    hstat_word[1]     = act_i[EXC_BUS];
    hstat_word[3]     = act_i[EXC_USE];
    hstat_word[7]     = act_i[EXC_SVC];
    hstat_word[8]     = act_i[EXC_DBG];
    hstat_word[10]    = act_i[EXC_DEF];
    hstat_word[11]    = act_i[EXC_TMR];
    hstat_word[12]    = pend_i[EXC_USE];
    hstat_word[13]    = pend_i[EXC_MEM];
    hstat_word[14]    = pend_i[EXC_BUS];
    hstat_word[15]    = pend_i[EXC_SVC];
    hstat_word[18:16] = fault_en_i;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LANE_W-1:0] lane;
    always_comb begin
      lane = '0;
      for (int k = 0; k < NUM_PRIO / LANES; k++)
        if (pri_idx_i == k[1:0]) lane[PRIO_W-1:0] = prio_i[(k*LANES+j)*PRIO_W +: PRIO_W];
    end
    assign pri_word[j*LANE_W +: LANE_W] = lane;
  end

  always_comb begin
    unique case (sel_i)
      SEL_TYPE:  rdata_o = TYPE_VAL;
      SEL_CTRL:  rdata_o = ctrl_word;
      SEL_VTO:   rdata_o = vto_i;
      SEL_RST:   rdata_o = RST_READ;
      SEL_PRI:   rdata_o = pri_word;
      SEL_HSTAT: rdata_o = hstat_word;
      default:   rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/exc_sysreg_file.sv
module exc_sysreg_file
  import exc_regs_pkg::*;
#(
  parameter int unsigned NUM_EXT_IRQ = 64,
  parameter int unsigned NUM_PRIO    = 12,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned VEC_W       = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [11:0]                addr_i,
  input  logic [31:0]                wdata_i,
  output logic [31:0]                rdata_o,
  output logic                       err_o,
  input  logic [15:0]                hw_set_i,
  input  logic                       ack_i,
  input  logic [3:0]                 ack_num_i,
  input  logic                       done_i,
  input  logic [3:0]                 done_num_i,
  input  logic [VEC_W-1:0]           active_vec_i,
  input  logic                       nested_i,
  input  logic [VEC_W-1:0]           pend_vec_i,
  input  logic                       ext_pend_i,
  output logic [15:0]                pend_o,
  output logic [15:0]                act_o,
  output logic [2:0]                 fault_en_o,
  output logic [NUM_PRIO*PRIO_W-1:0] prio_o,
  output logic [31:0]                vto_o,
  output logic                       sys_reset_o
);

  reg_sel_e    sel;
  logic [1:0]  pri_idx;
  logic [11:0] pri_off;
  logic        wr, rd, bad;
  logic [31:0] mux_data;
  logic        unused_off;

  assign sel        = decode_sel(addr_i);
  assign pri_off    = addr_i - OFS_PRI0;
  assign pri_idx    = pri_off[3:2];
  assign unused_off = ^{pri_off[11:4], pri_off[1:0]};
  assign bad        = req_i && (sel == SEL_NONE || (we_i && sel == SEL_TYPE));
  assign wr         = req_i && we_i && !bad;
  assign rd         = req_i && !we_i && !bad;

  exc_pend_state u_pend (
    .clk_i, .rst_ni,
    .ctrl_we_i  (wr && sel == SEL_CTRL),
    .wdata_i,
    .hw_set_i,
    .ack_i, .ack_num_i, .done_i, .done_num_i,
    .pend_o, .act_o
  );

  exc_cfg_regs #(.NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)) u_cfg (
    .clk_i, .rst_ni,
    .pri_we_i   (wr && sel == SEL_PRI),
    .pri_idx_i  (pri_idx),
    .hctl_we_i  (wr && sel == SEL_HSTAT),
    .vto_we_i   (wr && sel == SEL_VTO),
    .rst_we_i   (wr && sel == SEL_RST),
    .wdata_i,
    .prio_o, .fault_en_o, .vto_o, .sys_reset_o
  );

  exc_status_mux #(
    .NUM_EXT_IRQ(NUM_EXT_IRQ), .NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W), .VEC_W(VEC_W)
  ) u_mux (
    .sel_i      (sel),
    .pri_idx_i  (pri_idx),
    .pend_i     (pend_o),
    .act_i      (act_o),
    .fault_en_i (fault_en_o),
    .prio_i     (prio_o),
    .vto_i      (vto_o),
    .active_vec_i, .nested_i, .pend_vec_i, .ext_pend_i,
    .rdata_o    (mux_data)
  );

  assign rdata_o = rd ? mux_data : 32'd0;
  assign err_o   = bad;

  assert_err_reads_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == 32'd0));

  assert_base_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd && sel == SEL_CTRL && active_vec_i == '0) |-> rdata_o[11]);

endmodule

// File: tb/test_exc_sysreg_file.sv
module test_exc_sysreg_file;
  timeunit 1ns;
  timeprecision 100ps;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VT [NV] = '{
    '{1'b0, 12'h004, 32'h0,         32'h0000_0001, 1'b0, 8'd10}, // R10
    '{1'b0, 12'hD04, 32'h0,         32'h0000_0800, 1'b0, 8'd3},  // R3 reset
    '{1'b1, 12'hD04, 32'h9400_0000, 32'h0,         1'b0, 8'd1},
    '{1'b0, 12'hD04, 32'h0,         32'h9400_0800, 1'b0, 8'd1},  // R1
    '{1'b1, 12'hD04, 32'h1A00_0000, 32'h0,         1'b0, 8'd2},
    '{1'b0, 12'hD04, 32'h0,         32'h9000_0800, 1'b0, 8'd2},  // R2 set wins
    '{1'b1, 12'hD04, 32'h0800_0000, 32'h0,         1'b0, 8'd2},
    '{1'b0, 12'hD04, 32'h0,         32'h8000_0800, 1'b0, 8'd2},  // R2 clear
    '{1'b1, 12'hD18, 32'h4433_2211, 32'h0,         1'b0, 8'd5},
    '{1'b0, 12'hD18, 32'h0,         32'h4433_2211, 1'b0, 8'd5},  // R5
    '{1'b1, 12'hD20, 32'hA0B0_C0D0, 32'h0,         1'b0, 8'd5},
    '{1'b0, 12'hD20, 32'h0,         32'hA0B0_C0D0, 1'b0, 8'd5},  // R5
    '{1'b1, 12'hD08, 32'h2000_01FF, 32'h0,         1'b0, 8'd8},
    '{1'b0, 12'hD08, 32'h0,         32'h2000_0180, 1'b0, 8'd8},  // R8
    '{1'b1, 12'hD24, 32'hFFFF_FFFF, 32'h0,         1'b0, 8'd7},
    '{1'b0, 12'hD24, 32'h0,         32'h0007_0000, 1'b0, 8'd7},  // R7
    '{1'b1, 12'hD24, 32'h0002_0000, 32'h0,         1'b0, 8'd7},
    '{1'b0, 12'hD24, 32'h0,         32'h0002_0000, 1'b0, 8'd6},  // R6
    '{1'b0, 12'hD10, 32'h0,         32'h0,         1'b1, 8'd11}, // R11
    '{1'b1, 12'hD28, 32'hFFFF_FFFF, 32'h0,         1'b1, 8'd11}, // R11
    '{1'b0, 12'hD1C, 32'h0,         32'h0,         1'b0, 8'd11}  // R11 no side effect
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        err;
  logic [15:0] hw_set = '0;
  logic        ack = 1'b0, done = 1'b0;
  logic [3:0]  ack_num = '0, done_num = '0;
  logic [8:0]  act_vec = '0, pnd_vec = '0;
  logic        nested = 1'b0, ext_pend = 1'b0;
  logic [15:0] pend, act;
  logic [2:0]  fen;
  logic [95:0] prio;
  logic [31:0] vto;
  logic        sys_rst;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  exc_sysreg_file i_exc_sysreg_file (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .err_o(err), .hw_set_i(hw_set),
    .ack_i(ack), .ack_num_i(ack_num), .done_i(done), .done_num_i(done_num),
    .active_vec_i(act_vec), .nested_i(nested), .pend_vec_i(pnd_vec),
    .ext_pend_i(ext_pend), .pend_o(pend), .act_o(act), .fault_en_o(fen),
    .prio_o(prio), .vto_o(vto), .sys_reset_o(sys_rst)
  );

  task automatic chk(input string tag, input logic [95:0] got, input logic [95:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic access(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req = 1'b0; we = 1'b0; hw_set = '0; ack = 1'b0; done = 1'b0;
    #1;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 reset pend", pend, 0);
    chk("R12 reset act", act, 0);
    chk("R9 reset pulse", sys_rst, 0);
    chk("R8 reset base", vto, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      access(VT[i].we, VT[i].addr, VT[i].wd);
      if (!VT[i].we) chk($sformatf("R%0d table %0d rdata", VT[i].req, i), rdata, VT[i].exp);
      chk($sformatf("R%0d table %0d err", VT[i].req, i), err, VT[i].err);
    end
    idle();
    chk("R5 prio_o bytes", prio, 96'hA0B0C0D0_00000000_44332211);
    chk("R7 fault_en_o", fen, 3'b010);
    chk("R8 vto_o", vto, 32'h2000_0180);
    chk("R11 pend unchanged", pend, 16'h0004);

    access(1'b0, 12'hD0C, 32'h0);
    chk("R9 reset read", rdata, 32'hFA05_0000);
    access(1'b1, 12'h004, 32'hFFFF_FFFF);
    chk("R11 write type err", err, 1);
    access(1'b1, 12'hD0C, 32'h05FA_0004);
    idle();
    chk("R9 pulse high", sys_rst, 1);
    idle();
    chk("R9 pulse one cycle", sys_rst, 0);
    access(1'b1, 12'hD0C, 32'h05FB_0001);
    idle();
    chk("R9 bad key", sys_rst, 0);
    access(1'b1, 12'hD0C, 32'h05FA_0002);
    idle();
    chk("R9 no reset bit", sys_rst, 0);
    access(1'b1, 12'hD0C, 32'h05FA_0001);
    idle();
    chk("R9 bit0 pulse", sys_rst, 1);

    @(negedge clk); hw_set = 16'h8018; // 15, 4, and unimplemented 3
    idle();
    chk("R12 hw set", pend, 16'h8014);
    access(1'b0, 12'hD24, 32'h0);
    chk("R6 mem pending", rdata, 32'h0002_2000);
    @(negedge clk); req = 1'b0; ack = 1'b1; ack_num = 4'd4;
    idle();
    chk("R12 ack act", act, 16'h0010);
    chk("R12 ack clears pend", pend, 16'h8004);
    access(1'b0, 12'hD24, 32'h0);
    chk("R6 mem active", rdata, 32'h0002_0001);
    act_vec = 9'd4; nested = 1'b1; pnd_vec = 9'd15; ext_pend = 1'b1;
    access(1'b0, 12'hD04, 32'h0);
    chk("R3 composed", rdata, 32'h8440_F004);
    nested = 1'b0;
    #1;
    chk("R4 base flag", rdata, 32'h8440_F804);
    act_vec = '0; pnd_vec = '0; ext_pend = 1'b0;

    access(1'b1, 12'hD24, 32'h0000_0000);
    idle();
    chk("R7 hctl keeps active", act, 16'h0010);
    chk("R7 enables cleared", fen, 3'b000);

    @(negedge clk); req = 1'b1; we = 1'b1; addr = 12'hD04; wdata = 32'h0200_0000;
    hw_set = 16'h8000;
    idle();
    chk("R12 hw set beats clear", pend[15], 1);
    access(1'b1, 12'hD04, 32'h0200_0000);
    idle();
    chk("R2 timer clear", pend[15], 0);
    @(negedge clk); done = 1'b1; done_num = 4'd4;
    idle();
    chk("R12 done clears", act, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule